// File: doc/BRIEF.md
# PCI Bridge Address Window Decoder

This block is the claim-and-forward decision logic of a PCI-to-PCI bridge. Every cycle seen on either side of the bridge is presented to it already decoded: address, command kind, configuration type and whether the address came from a dual address cycle. The block compares that cycle against its bus-number registers, its I/O window and its memory window, and against two legacy control bits. One of these bits forwards the legacy display ranges. The other keeps the ISA alias ranges upstream. From this comparison it reports whether the bridge claims the cycle, whether it forwards the cycle to the other side, and whether a configuration cycle must be rewritten from Type 1 to Type 0.

Downstream cycles are those seen on the primary side. They are claimed when they fall inside a window or a legacy range. Upstream cycles are those seen on the secondary side. They use the inverse decode: anything that does not belong below the bridge is passed up. This includes 64-bit addresses above 4 GB carried by a dual address cycle. A window whose base is all ones and whose limit is all zeros matches nothing. Configuration cycles are handled as follows. Type 0 cycles are never claimed, so no function can show up on more than one bus. Type 1 cycles are claimed only for buses that lie behind the bridge.

The electrical protocol, arbitration and data buffering are handled elsewhere. Registers are loaded through a simple select/data write port.

Top module: `bwd_top`

## Requirements
- R1: After reset both windows are closed, the secondary and subordinate bus numbers are 0, both legacy control bits are 0, and all three outputs are 0.
- R2: `claimOut`, `fwdOut` and `toType0Out` reflect the cycle presented with `cycValid` high at the previous rising edge. They are all 0 in the cycle after an edge where `cycValid` was low. A claimed cycle always has `fwdOut` equal to `claimOut`.
- R3: For a downstream memory cycle (`cycDir`=0, `cycKind`=0), the bridge claims when base <= address[63:20] <= limit. Here base is {upper-base, lower-base} and limit is {upper-limit, lower-limit}, which gives a 1 MB granularity over a 64-bit space.
- R4: A window whose base fields are all ones and whose limit fields are all zeros claims no address. This is also the reset state of both windows.
- R5: For a downstream I/O cycle (`cycKind`=1), the bridge claims when address[63:16] is 0 and io-base <= address[15:12] <= io-limit. Addresses at or above 0x10000 never match.
- R6: With the ISA bit set, a downstream I/O address below 0x10000 whose offset within its 1 KB block (address[9:8] nonzero) is 0x100 to 0x3FF is not claimed, even when it lies inside the I/O window.
- R7: With the VGA bit set, downstream memory 0xA0000 to 0xBFFFF is claimed regardless of the window. So are I/O addresses below 0x10000 whose low 10 bits lie in 0x3B0 to 0x3BB or 0x3C0 to 0x3DF, and this I/O rule takes precedence over R6.
- R8: For a downstream Type 1 configuration cycle (`cycKind`=2, `cycType1`=1), the bus number is address[23:16]. A bus equal to the secondary bus is claimed with `toType0Out`=1. A bus above the secondary bus and no greater than the subordinate bus is claimed as Type 1. Any other bus is not claimed. Configuration cycles seen upstream are never claimed.
- R9: Type 0 configuration cycles and command kind 3 are never claimed in either direction.
- R10: For an upstream memory cycle (`cycDir`=1), the bridge claims exactly when the R3/R7 downstream test fails. With `cycDac`=1 all 64 address bits are decoded. With `cycDac`=0 address[63:32] is treated as 0.
- R11: For an upstream I/O cycle, the bridge claims exactly when the R5/R6/R7 downstream test fails.
- R12: The write port encoding is as follows. `regSel` 0 loads secondary[7:0] and subordinate[15:8]. `regSel` 1 loads io-base[3:0] and io-limit[11:8]. `regSel` 2 loads lower-base[11:0] and lower-limit[27:16]. `regSel` 3 loads upper-base[31:0]. `regSel` 4 loads upper-limit[31:0]. `regSel` 5 loads ISA[0] and VGA[1]. `regSel` 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| cycValid | input | 1 | A decoded cycle is presented |
| cycDir | input | 1 | 0 = seen on primary (downstream), 1 = seen on secondary (upstream) |
| cycKind | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 reserved |
| cycType1 | input | 1 | Configuration cycle is Type 1 |
| cycDac | input | 1 | Address came from a dual address cycle |
| cycAddr | input | 64 | Cycle address |
| claimOut | output | 1 | Bridge claims the cycle |
| fwdOut | output | 1 | Cycle is forwarded to the other side |
| toType0Out | output | 1 | Type 1 cycle is converted to Type 0 |

## Verification
Every decision is due exactly one rising edge after the cycle is presented. The bench drives each cycle on a falling edge and compares the three outputs at the next falling edge, before the next cycle is driven. A register write becomes visible to the decode for any cycle presented after its write edge, so the checks follow each write with at least one full cycle. The quiet rule of R2 is checked on the falling edge after an idle edge.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam logic [1:0] KIND_MEM  = 2'd0;
  localparam logic [1:0] KIND_IO   = 2'd1;
  localparam logic [1:0] KIND_CFG  = 2'd2;

  localparam logic [2:0] SEL_BUS    = 3'd0;
  localparam logic [2:0] SEL_IO     = 3'd1;
  localparam logic [2:0] SEL_MEMLO  = 3'd2;
  localparam logic [2:0] SEL_MEMHIB = 3'd3;
  localparam logic [2:0] SEL_MEMHIL = 3'd4;
  localparam logic [2:0] SEL_CTRL   = 3'd5;

  typedef struct packed {
    logic ldBus;
    logic ldIo;
    logic ldMemLo;
    logic ldMemHiBase;
    logic ldMemHiLim;
    logic ldCtrl;
  } regStrobe_t;

  typedef struct packed {
    logic memHit;
    logic vgaMemHit;
    logic ioHit;
    logic vgaIoHit;
    logic isaBlock;
    logic busIsSec;
    logic busBelow;
  } hitFlags_t;
endpackage

// File: rtl/bwd_datapath.sv
module bwd_datapath import bwd_pkg::*; #(
  parameter int ADDR_W        = 64,
  parameter int DATA_W        = 32,
  parameter int BUS_W         = 8,
  parameter int IO_SPACE_W    = 16,
  parameter int IO_GRAN_LOG2  = 12,
  parameter int MEM_GRAN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cycDac,
  input  logic [ADDR_W-1:0] cycAddr,
  output hitFlags_t         flags
);
  localparam int IO_FW    = IO_SPACE_W - IO_GRAN_LOG2;
  localparam int MEM_LO_W = 32 - MEM_GRAN_LOG2;
  localparam int MEM_HI_W = ADDR_W - 32;
  localparam int PAGE_W   = ADDR_W - MEM_GRAN_LOG2;
  localparam int VGA_W    = ADDR_W - 17;

  logic [BUS_W-1:0]    secBus, subBus;
  logic [IO_FW-1:0]    ioBase, ioLimit;
  logic [MEM_LO_W-1:0] memBaseLo, memLimLo;
  logic [MEM_HI_W-1:0] memBaseHi, memLimHi;
  logic                isaEn, vgaEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secBus    <= '0;
      subBus    <= '0;
      ioBase    <= '1;
      ioLimit   <= '0;
      memBaseLo <= '1;
      memLimLo  <= '0;
      memBaseHi <= '1;
      memLimHi  <= '0;
      isaEn     <= 1'b0;
      vgaEn     <= 1'b0;
    end else begin
      if (strobe.ldBus) begin
        secBus <= wrData[BUS_W-1:0];
        subBus <= wrData[8 +: BUS_W];
      end
      if (strobe.ldIo) begin
        ioBase  <= wrData[IO_FW-1:0];
        ioLimit <= wrData[8 +: IO_FW];
      end
      if (strobe.ldMemLo) begin
        memBaseLo <= wrData[MEM_LO_W-1:0];
        memLimLo  <= wrData[16 +: MEM_LO_W];
      end
      if (strobe.ldMemHiBase) memBaseHi <= wrData[MEM_HI_W-1:0];
      if (strobe.ldMemHiLim)  memLimHi  <= wrData[MEM_HI_W-1:0];
      if (strobe.ldCtrl) begin
        isaEn <= wrData[0];
        vgaEn <= wrData[1];
      end
    end
  end

  logic [ADDR_W-1:0] effAddr;
  logic [PAGE_W-1:0] memPage, memBase, memLim;
  logic [IO_FW-1:0]  ioPage;
  logic [9:0]        lo10;
  logic              ioInSpace;
  logic [BUS_W-1:0]  cfgBus;

  always_comb begin
    effAddr   = cycDac ? cycAddr : {{MEM_HI_W{1'b0}}, cycAddr[31:0]};
    memPage   = effAddr[ADDR_W-1:MEM_GRAN_LOG2];
    memBase   = {memBaseHi, memBaseLo};
    memLim    = {memLimHi, memLimLo};
    ioPage    = effAddr[IO_SPACE_W-1:IO_GRAN_LOG2];
    lo10      = effAddr[9:0];
    ioInSpace = (effAddr[ADDR_W-1:IO_SPACE_W] == '0);
    cfgBus    = cycAddr[16 +: BUS_W];

    flags.memHit    = (memPage >= memBase) && (memPage <= memLim);
    flags.vgaMemHit = vgaEn && (effAddr[ADDR_W-1:17] == VGA_W'(5));
    flags.ioHit     = ioInSpace && (ioPage >= ioBase) && (ioPage <= ioLimit);
    flags.vgaIoHit  = vgaEn && ioInSpace &&
                      (((lo10 >= 10'h3B0) && (lo10 <= 10'h3BB)) ||
                       ((lo10 >= 10'h3C0) && (lo10 <= 10'h3DF)));
    flags.isaBlock  = isaEn && ioInSpace && (lo10[9:8] != 2'b00);
    flags.busIsSec  = (cfgBus == secBus);
    flags.busBelow  = (cfgBus > secBus) && (cfgBus <= subBus);
  end

  // R4: a window held closed matches nothing
  a_r4_mem_closed: assert property (@(posedge clk) disable iff (!rstN)
    ((memBase == '1) && (memLim == '0)) |-> !flags.memHit);
  a_r4_io_closed: assert property (@(posedge clk) disable iff (!rstN)
    ((ioBase == '1) && (ioLimit == '0)) |-> !flags.ioHit);
  // R5: above the 64 KB I/O space no window hit
  a_r5_io_space: assert property (@(posedge clk) disable iff (!rstN)
    !ioInSpace |-> !(flags.ioHit || flags.vgaIoHit || flags.isaBlock));
endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl import bwd_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regSel,
  input  logic       cycValid,
  input  logic       cycDir,
  input  logic [1:0] cycKind,
  input  logic       cycType1,
  input  hitFlags_t  flags,
  output regStrobe_t strobe,
  output logic       claimOut,
  output logic       fwdOut,
  output logic       toType0Out
);
  always_comb begin
    strobe             = '0;
    strobe.ldBus       = regWrEn && (regSel == SEL_BUS);
    strobe.ldIo        = regWrEn && (regSel == SEL_IO);
    strobe.ldMemLo     = regWrEn && (regSel == SEL_MEMLO);
    strobe.ldMemHiBase = regWrEn && (regSel == SEL_MEMHIB);
    strobe.ldMemHiLim  = regWrEn && (regSel == SEL_MEMHIL);
    strobe.ldCtrl      = regWrEn && (regSel == SEL_CTRL);
  end

  logic downMem, downIo, claimNext, type0Next;

  always_comb begin
    downMem   = flags.memHit || flags.vgaMemHit;
    downIo    = (flags.ioHit && !flags.isaBlock) || flags.vgaIoHit;
    claimNext = 1'b0;
    type0Next = 1'b0;
    case (cycKind)
      KIND_MEM: claimNext = cycDir ? !downMem : downMem;
      KIND_IO:  claimNext = cycDir ? !downIo : downIo;
      KIND_CFG: if (!cycDir && cycType1) begin
        claimNext = flags.busIsSec || flags.busBelow;
        type0Next = flags.busIsSec;
      end
      default: claimNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      claimOut   <= 1'b0;
      fwdOut     <= 1'b0;
      toType0Out <= 1'b0;
    end else begin
      claimOut   <= cycValid && claimNext;
      fwdOut     <= cycValid && claimNext;
      toType0Out <= cycValid && type0Next;
    end
  end

  // R2: nothing is reported after an idle edge
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> !(claimOut || fwdOut || toType0Out));
  // R9: Type 0 configuration cycles are never claimed
  a_r9_type0_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && (cycKind == KIND_CFG) && !cycType1) |=> !claimOut);
  // R8: upstream configuration cycles are never claimed
  a_r8_upstream_cfg: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycDir && (cycKind == KIND_CFG)) |=> !claimOut);
  // R8: conversion only on a claimed, forwarded cycle
  a_r8_convert_claimed: assert property (@(posedge clk) disable iff (!rstN)
    toType0Out |-> (claimOut && fwdOut));
  // R6: ISA alias range without VGA override stays upstream
  a_r6_isa_block: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !cycDir && (cycKind == KIND_IO) && flags.isaBlock && !flags.vgaIoHit)
      |=> !claimOut);
endmodule

// File: rtl/bwd_top.sv
module bwd_top import bwd_pkg::*; #(
  parameter int ADDR_W        = 64,
  parameter int DATA_W        = 32,
  parameter int BUS_W         = 8,
  parameter int IO_SPACE_W    = 16,
  parameter int IO_GRAN_LOG2  = 12,
  parameter int MEM_GRAN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cycValid,
  input  logic              cycDir,
  input  logic [1:0]        cycKind,
  input  logic              cycType1,
  input  logic              cycDac,
  input  logic [ADDR_W-1:0] cycAddr,
  output logic              claimOut,
  output logic              fwdOut,
  output logic              toType0Out
);
  regStrobe_t strobe;
  hitFlags_t  flags;

  bwd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .cycValid(cycValid), .cycDir(cycDir), .cycKind(cycKind), .cycType1(cycType1),
    .flags(flags), .strobe(strobe),
    .claimOut(claimOut), .fwdOut(fwdOut), .toType0Out(toType0Out)
  );

  bwd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .IO_SPACE_W(IO_SPACE_W),
    .IO_GRAN_LOG2(IO_GRAN_LOG2), .MEM_GRAN_LOG2(MEM_GRAN_LOG2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .cycDac(cycDac), .cycAddr(cycAddr), .flags(flags)
  );
endmodule

// File: tb/bwd_top_tb_top.sv
`timescale 1ns/1ps
module bwd_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWrData = '0;
  logic        cycValid = 1'b0, cycDir = 1'b0, cycType1 = 1'b0, cycDac = 1'b0;
  logic [1:0]  cycKind = '0;
  logic [63:0] cycAddr = '0;
  logic        claimOut, fwdOut, toType0Out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // shadow of the programmed state, kept by the bench
  logic [7:0]  shSec = 0, shSub = 0;
  logic [3:0]  shIoB = 4'hF, shIoL = 0;
  logic [11:0] shMemLoB = 12'hFFF, shMemLoL = 0;
  logic [31:0] shMemHiB = 32'hFFFF_FFFF, shMemHiL = 0;
  logic        shIsa = 0, shVga = 0;

  always #4 clk = ~clk;

  bwd_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .cycValid(cycValid), .cycDir(cycDir), .cycKind(cycKind), .cycType1(cycType1),
    .cycDac(cycDac), .cycAddr(cycAddr),
    .claimOut(claimOut), .fwdOut(fwdOut), .toType0Out(toType0Out)
  );

  function automatic logic [2:0] refDecode(input logic dir, input logic [1:0] kind,
      input logic t1, input logic dac, input logic [63:0] addr);
    logic [63:0] ea;
    logic [43:0] page;
    logic [9:0]  lo;
    logic        inIo, ioW, vIo, isaX, down;
    logic [7:0]  bus;
    ea = dac ? addr : {32'h0, addr[31:0]};
    page = ea[63:20];
    refDecode = 3'b000;
    if (kind == 2'd0) begin
      down = (page >= {shMemHiB, shMemLoB} && page <= {shMemHiL, shMemLoL}) ||
             (shVga && ea >= 64'hA0000 && ea <= 64'hBFFFF);
      if (dir ? !down : down) refDecode = 3'b110;
    end else if (kind == 2'd1) begin
      inIo = ea < 64'h10000;
      lo   = ea[9:0];
      ioW  = inIo && ea[15:12] >= shIoB && ea[15:12] <= shIoL;
      isaX = shIsa && inIo && lo >= 10'h100;
      vIo  = shVga && inIo && ((lo >= 10'h3B0 && lo <= 10'h3BB) ||
                               (lo >= 10'h3C0 && lo <= 10'h3DF));
      down = (ioW && !isaX) || vIo;
      if (dir ? !down : down) refDecode = 3'b110;
    end else if (kind == 2'd2 && !dir && t1) begin
      bus = addr[23:16];
      if (bus == shSec) refDecode = 3'b111;
      else if (bus > shSec && bus <= shSub) refDecode = 3'b110;
    end
  endfunction

  task automatic check3(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: claim/fwd/type0 actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    case (sel)
      3'd0: begin shSec = data[7:0]; shSub = data[15:8]; end
      3'd1: begin shIoB = data[3:0]; shIoL = data[11:8]; end
      3'd2: begin shMemLoB = data[11:0]; shMemLoL = data[27:16]; end
      3'd3: shMemHiB = data;
      3'd4: shMemHiL = data;
      3'd5: begin shIsa = data[0]; shVga = data[1]; end
      default: ;
    endcase
  endtask

  // drive on a falling edge, result due after the next rising edge
  task automatic runCyc(input string tag, input logic dir, input logic [1:0] kind,
      input logic t1, input logic dac, input logic [63:0] addr);
    logic [2:0] exp;
    exp = refDecode(dir, kind, t1, dac, addr);
    @(negedge clk);
    cycValid = 1'b1; cycDir = dir; cycKind = kind; cycType1 = t1; cycDac = dac; cycAddr = addr;
    @(negedge clk);
    cycValid = 1'b0;
    check3(tag, {claimOut, fwdOut, toType0Out}, exp);
  endtask

  task automatic dirCyc(input string tag, input logic dir, input logic [1:0] kind,
      input logic t1, input logic dac, input logic [63:0] addr, input logic [2:0] exp);
    @(negedge clk);
    cycValid = 1'b1; cycDir = dir; cycKind = kind; cycType1 = t1; cycDac = dac; cycAddr = addr;
    @(negedge clk);
    cycValid = 1'b0;
    check3(tag, {claimOut, fwdOut, toType0Out}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0]  sel;
    logic [31:0] d;
    logic [1:0]  kind;
    logic [63:0] a;
    string tag;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check3("R1 outputs", {claimOut, fwdOut, toType0Out}, 3'b000);
    dirCyc("R1 mem closed", 0, 2'd0, 0, 0, 64'h0, 3'b000);
    dirCyc("R1 io closed", 0, 2'd1, 0, 0, 64'h3F8, 3'b000);
    dirCyc("R1 vga off", 0, 2'd0, 0, 0, 64'hA0000, 3'b000);
    dirCyc("R10 upstream passes all", 1, 2'd0, 0, 0, 64'h1234_5678, 3'b110);
    // R2: quiet after idle edge
    @(negedge clk);
    check3("R2 idle", {claimOut, fwdOut, toType0Out}, 3'b000);
    // R3/R12: 32-bit memory window 0x1000_0000..0x1FFF_FFFF
    wrReg(3'd3, 32'h0); wrReg(3'd4, 32'h0);
    wrReg(3'd2, 32'h01FF_0100);
    dirCyc("R3 base edge", 0, 2'd0, 0, 0, 64'h1000_0000, 3'b110);
    dirCyc("R3 limit edge", 0, 2'd0, 0, 0, 64'h1FFF_FFFF, 3'b110);
    dirCyc("R3 above", 0, 2'd0, 0, 0, 64'h2000_0000, 3'b000);
    dirCyc("R3 below", 0, 2'd0, 0, 0, 64'h0FFF_FFFF, 3'b000);
    dirCyc("R10 upstream inside", 1, 2'd0, 0, 0, 64'h1800_0000, 3'b000);
    // R12: unused selects change nothing
    wrReg(3'd6, 32'h0000_0000); wrReg(3'd7, 32'hFFFF_FFFF);
    dirCyc("R12 sel6/7 ignored", 0, 2'd0, 0, 0, 64'h1000_0000, 3'b110);
    // R4: closed window
    wrReg(3'd2, 32'h0000_0FFF); wrReg(3'd3, 32'hFFFF_FFFF); wrReg(3'd4, 32'h0);
    dirCyc("R4 closed low", 0, 2'd0, 0, 0, 64'h1000_0000, 3'b000);
    dirCyc("R4 closed top", 0, 2'd0, 0, 1, 64'hFFFF_FFFF_FFF0_0000, 3'b000);
    // R10: 64-bit window 0x1_0000_0000..0x1_FFFF_FFFF
    wrReg(3'd3, 32'h1); wrReg(3'd4, 32'h1); wrReg(3'd2, 32'h0FFF_0000);
    dirCyc("R10 dac above", 1, 2'd0, 0, 1, 64'h2_0000_0000, 3'b110);
    dirCyc("R10 dac inside", 1, 2'd0, 0, 1, 64'h1_8000_0000, 3'b000);
    dirCyc("R10 no dac high ignored", 1, 2'd0, 0, 0, 64'h1_8000_0000, 3'b110);
    dirCyc("R3 dac downstream", 0, 2'd0, 0, 1, 64'h1_8000_0000, 3'b110);
    // R5: I/O window 0x2000..0x3FFF
    wrReg(3'd1, 32'h0000_0302);
    dirCyc("R5 io base", 0, 2'd1, 0, 0, 64'h2000, 3'b110);
    dirCyc("R5 io limit", 0, 2'd1, 0, 0, 64'h3FFF, 3'b110);
    dirCyc("R5 io above", 0, 2'd1, 0, 0, 64'h4000, 3'b000);
    dirCyc("R5 io beyond 64K", 0, 2'd1, 0, 0, 64'h1_2000, 3'b000);
    dirCyc("R11 upstream io inside", 1, 2'd1, 0, 0, 64'h2100, 3'b000);
    dirCyc("R11 upstream io outside", 1, 2'd1, 0, 0, 64'h5000, 3'b110);
    // R6: ISA aliasing over full window
    wrReg(3'd1, 32'h0000_0F00); wrReg(3'd5, 32'h1);
    dirCyc("R6 isa low kept", 0, 2'd1, 0, 0, 64'h0050, 3'b110);
    dirCyc("R6 isa 0x150 blocked", 0, 2'd1, 0, 0, 64'h0150, 3'b000);
    dirCyc("R6 isa 0x4450 kept", 0, 2'd1, 0, 0, 64'h4450, 3'b110);
    dirCyc("R6 isa 0x7FF blocked", 0, 2'd1, 0, 0, 64'h07FF, 3'b000);
    dirCyc("R11 upstream isa alias", 1, 2'd1, 0, 0, 64'h0150, 3'b110);
    // R7: VGA ranges, windows closed
    wrReg(3'd1, 32'h0000_000F); wrReg(3'd2, 32'h0000_0FFF);
    wrReg(3'd3, 32'hFFFF_FFFF); wrReg(3'd4, 32'h0); wrReg(3'd5, 32'h2);
    dirCyc("R7 vga mem start", 0, 2'd0, 0, 0, 64'hA0000, 3'b110);
    dirCyc("R7 vga mem end", 0, 2'd0, 0, 0, 64'hBFFFF, 3'b110);
    dirCyc("R7 vga mem after", 0, 2'd0, 0, 0, 64'hC0000, 3'b000);
    dirCyc("R7 vga io 3B0", 0, 2'd1, 0, 0, 64'h3B0, 3'b110);
    dirCyc("R7 vga io 3BC", 0, 2'd1, 0, 0, 64'h3BC, 3'b000);
    dirCyc("R7 vga io alias 13C5", 0, 2'd1, 0, 0, 64'h13C5, 3'b110);
    dirCyc("R7 vga io 3DF", 0, 2'd1, 0, 0, 64'h3DF, 3'b110);
    dirCyc("R7 vga io 3E0", 0, 2'd1, 0, 0, 64'h3E0, 3'b000);
    dirCyc("R10 upstream vga mem", 1, 2'd0, 0, 0, 64'hA8000, 3'b000);
    wrReg(3'd5, 32'h3);
    dirCyc("R7 vga beats isa", 0, 2'd1, 0, 0, 64'h3C0, 3'b110);
    // R8/R9: configuration
    wrReg(3'd0, 32'h0000_0704);
    dirCyc("R8 bus sec", 0, 2'd2, 1, 0, 64'h0004_0800, 3'b111);
    dirCyc("R8 bus below", 0, 2'd2, 1, 0, 64'h0005_0800, 3'b110);
    dirCyc("R8 bus sub", 0, 2'd2, 1, 0, 64'h0007_0000, 3'b110);
    dirCyc("R8 bus past sub", 0, 2'd2, 1, 0, 64'h0008_0000, 3'b000);
    dirCyc("R8 bus before sec", 0, 2'd2, 1, 0, 64'h0003_0000, 3'b000);
    dirCyc("R8 upstream cfg", 1, 2'd2, 1, 0, 64'h0005_0000, 3'b000);
    dirCyc("R9 type0", 0, 2'd2, 0, 0, 64'h0004_0800, 3'b000);
    dirCyc("R9 kind3", 1, 2'd3, 0, 0, 64'h0, 3'b000);
    // random traffic against the bench model
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) begin
        sel = 3'($urandom % 6);
        d = $urandom;
        if (sel == 3'd0) d = {16'h0, 4'h0, 4'($urandom), 4'h0, 4'($urandom)};
        if (sel == 3'd3 || sel == 3'd4) d = $urandom % 3;
        wrReg(sel, d);
      end
      kind = 2'($urandom);
      case (kind)
        2'd0: a = {32'($urandom % 3), $urandom};
        2'd1: a = ($urandom % 8 == 0) ? {47'h0, 17'($urandom)} : {48'h0, 16'($urandom)};
        2'd2: a = {40'h0, 4'h0, 4'($urandom), 16'($urandom)};
        default: a = {$urandom, $urandom};
      endcase
      case (kind)
        2'd0: tag = "R3/R10 random mem";
        2'd1: tag = "R5/R11 random io";
        2'd2: tag = "R8 random cfg";
        default: tag = "R9 random reserved";
      endcase
      runCyc(tag, 1'($urandom), kind, 1'($urandom), 1'($urandom), a);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule